// File: doc/BRIEF.md
# Test Point Shift Register Chain

This block wraps a small piece of logic with two kinds of test point, each kind linked into its own serial shift chain. Observation cells give access to internal nodes that are hard to observe. When scan enable is low, each cell loads its node into a flip-flop. When scan enable is high, the cells form a shift register, so the captured values can be read out one bit per clock at the chain's scan output.

Control cells sit between a source signal and its destination. When test mode is low, every destination follows its source directly through combinational logic. When test mode is high, each destination is driven by the cell's flip-flop instead. In that state the control chain shifts one position on every clock, loading a chosen override pattern from its own scan input.

The two chains share the clock and reset and nothing else. A tester can fill the override pattern while a snapshot of the nodes is being shifted out. Both chains are plain serial scan paths with no handshake, because every clock moves exactly one bit.

Top module: `test_point_chains`

## Requirements
- R1: A synchronous active-high reset clears every observation and control flip-flop to 0 on the rising clock edge, and reset takes priority over shifting and capture.
- R2: With scan enable low, each rising edge loads observed node i into observation cell i.
- R3: With scan enable high, each rising edge moves observation cell i into cell i+1 and loads the observation scan input into cell 0. The observation scan output always shows the last cell.
- R4: With test mode high, each rising edge moves control cell i into cell i+1 and loads the control scan input into cell 0. With test mode low, the control cells hold their contents.
- R5: With test mode low, destination i equals source i combinationally, whatever the control cells hold.
- R6: With test mode high, destination i equals control cell i, and the control scan output shows the last control cell.
- R7: After exactly N shift clocks on a chain, the first bit shifted in is in the last cell (index N-1) and the last bit shifted in is in cell 0. Read-out order is therefore cell N-1 first, then down to cell 0.
- R8: Scan enable has no effect on the control chain, and test mode has no effect on the observation chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all cells |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1: observation chain shifts; 0: observation cells capture nodes |
| test_mode | input | 1 | 1: control chain shifts and drives destinations; 0: sources pass through |
| obs_si | input | 1 | Serial input of the observation chain |
| ctl_si | input | 1 | Serial input of the control chain |
| obs_node | input | N_OBS | Internal nodes sampled by the observation cells |
| ctl_src | input | N_CTL | Functional source signals |
| ctl_dst | output | N_CTL | Destination signals, source or override value |
| obs_so | output | 1 | Serial output of the observation chain (last cell) |
| ctl_so | output | 1 | Serial output of the control chain (last cell) |

## Verification
The two chains can act in the same clock: an observation capture or shift can coincide with a control-chain shift. The bench provokes this by loading every 4-bit override pattern while it captures and unloads every 4-bit node pattern. It judges the two independently: the bits read from the observation output must match the captured nodes in R7 order, and the destinations after the fourth shift must equal the loaded pattern. Separate passes toggle scan enable while the control chain holds, and toggle test mode during a capture, to confirm that each chain's control signal does not reach the other chain.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Default number of test points on each chain.
  localparam int unsigned TP_DEFAULT_POINTS = 4;
endpackage

// File: rtl/tp_obs_cell.sv
module tp_obs_cell (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic si,
  input  logic node,
  output logic q
);
  // Capture/shift mux in front of a single flop.
  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (scan_en) q <= si;
    else              q <= node;
  end
endmodule

// File: rtl/tp_ctl_cell.sv
module tp_ctl_cell (
  input  logic clk,
  input  logic rst,
  input  logic test_mode,
  input  logic si,
  input  logic src,
  output logic q,
  output logic dst
);
  // Flop shifts only in test mode; otherwise it keeps its value.
  always_ff @(posedge clk) begin
    if (rst)            q <= 1'b0;
    else if (test_mode) q <= si;
  end

  // Override mux: input 0 is the functional source, input 1 the flop.
  assign dst = test_mode ? q : src;
endmodule

// File: rtl/tp_obs_chain.sv
module tp_obs_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             si,
  input  logic [WIDTH-1:0] node,
  output logic [WIDTH-1:0] q,
  output logic             so
);
  localparam int unsigned LINKS = WIDTH + 1;

  logic [LINKS-1:0] link;
  assign link[0] = si;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    tp_obs_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .scan_en (scan_en),
      .si      (link[i]),
      .node    (node[i]),
      .q       (link[i+1])
    );
  end

  assign q  = link[LINKS-1:1];
  assign so = link[LINKS-1];
endmodule

// File: rtl/tp_ctl_chain.sv
module tp_ctl_chain #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_mode,
  input  logic             si,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst,
  output logic [WIDTH-1:0] q,
  output logic             so
);
  localparam int unsigned LINKS = WIDTH + 1;

  logic [LINKS-1:0] link;
  assign link[0] = si;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    tp_ctl_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .test_mode (test_mode),
      .si        (link[i]),
      .src       (src[i]),
      .q         (link[i+1]),
      .dst       (dst[i])
    );
  end

  assign q  = link[LINKS-1:1];
  assign so = link[LINKS-1];
endmodule

// File: rtl/test_point_chains.sv
module test_point_chains
  import tp_pkg::*;
#(
  parameter int unsigned N_OBS = TP_DEFAULT_POINTS,
  parameter int unsigned N_CTL = TP_DEFAULT_POINTS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             test_mode,
  input  logic             obs_si,
  input  logic             ctl_si,
  input  logic [N_OBS-1:0] obs_node,
  input  logic [N_CTL-1:0] ctl_src,
  output logic [N_CTL-1:0] ctl_dst,
  output logic             obs_so,
  output logic             ctl_so
);
  logic [N_OBS-1:0] obs_q;
  logic [N_CTL-1:0] ctl_q;

  tp_obs_chain #(.WIDTH(N_OBS)) u_obs (
    .clk     (clk),
    .rst     (rst),
    .scan_en (scan_en),
    .si      (obs_si),
    .node    (obs_node),
    .q       (obs_q),
    .so      (obs_so)
  );

  tp_ctl_chain #(.WIDTH(N_CTL)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .si        (ctl_si),
    .src       (ctl_src),
    .dst       (ctl_dst),
    .q         (ctl_q),
    .so        (ctl_so)
  );
endmodule

// File: rtl/test_point_chains_chk.sv
module test_point_chains_chk #(
  parameter int unsigned N_OBS = 4,
  parameter int unsigned N_CTL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             scan_en,
  input logic             test_mode,
  input logic             obs_si,
  input logic             ctl_si,
  input logic [N_OBS-1:0] obs_node,
  input logic [N_CTL-1:0] ctl_src,
  input logic [N_CTL-1:0] ctl_dst,
  input logic [N_OBS-1:0] obs_q,
  input logic [N_CTL-1:0] ctl_q
);
  AST_OBS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> obs_q == $past(obs_node)); // R2

  AST_OBS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> obs_q == N_OBS'({$past(obs_q), $past(obs_si)})); // R3

  AST_CTL_SHIFT: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> ctl_q == N_CTL'({$past(ctl_q), $past(ctl_si)})); // R4

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> $stable(ctl_q)); // R4

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !test_mode |-> ctl_dst == ctl_src); // R5

  AST_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> ctl_dst == ctl_q); // R6
endmodule

bind test_point_chains test_point_chains_chk #(.N_OBS(N_OBS), .N_CTL(N_CTL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scan_en   (scan_en),
  .test_mode (test_mode),
  .obs_si    (obs_si),
  .ctl_si    (ctl_si),
  .obs_node  (obs_node),
  .ctl_src   (ctl_src),
  .ctl_dst   (ctl_dst),
  .obs_q     (obs_q),
  .ctl_q     (ctl_q)
);

// File: tb/tb_test_point_chains.sv
module tb_test_point_chains;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_en = 1'b0;
  logic         test_mode = 1'b0;
  logic         obs_si = 1'b0;
  logic         ctl_si = 1'b0;
  logic [N-1:0] obs_node = '0;
  logic [N-1:0] ctl_src = '0;
  logic [N-1:0] ctl_dst;
  logic         obs_so;
  logic         ctl_so;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  test_point_chains #(.N_OBS(N), .N_CTL(N)) dut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .test_mode(test_mode),
    .obs_si(obs_si), .ctl_si(ctl_si), .obs_node(obs_node), .ctl_src(ctl_src),
    .ctl_dst(ctl_dst), .obs_so(obs_so), .ctl_so(ctl_so)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One rising edge, then settle away from it.
  task automatic edge1();
    @(posedge clk);
    #2;
  endtask

  initial begin
    // R1: reset state, with test mode high so cells show at destinations
    test_mode = 1'b1;
    ctl_si = 1'b1;
    obs_si = 1'b1;
    scan_en = 1'b1;
    edge1();
    edge1();
    chk("R1 ctl_dst in reset", ctl_dst, 0);
    chk("R1 obs_so in reset", obs_so, 0);
    chk("R1 ctl_so in reset", ctl_so, 0);
    rst = 1'b0;
    test_mode = 1'b0;
    scan_en = 1'b0;

    // Control sweep over all patterns.
    for (int p = 0; p < 16; p++) begin
      test_mode = 1'b1;
      for (int k = 0; k < N; k++) begin
        ctl_si = p[N-1-k];   // R7: first bit lands in last cell
        edge1();
      end
      chk("R6 R7 override pattern", ctl_dst, p);
      chk("R6 ctl_so last cell", ctl_so, p[N-1]);
      // R5: pass-through in functional mode
      test_mode = 1'b0;
      for (int s = 0; s < 16; s += 5) begin
        ctl_src = s[N-1:0];
        #1;
        chk("R5 pass-through", ctl_dst, s);
      end
      // R4 hold and R8: scan_en and ctl_si toggling must not disturb cells
      for (int h = 0; h < 3; h++) begin
        ctl_si = ~ctl_si;
        scan_en = ~scan_en;
        edge1();
      end
      scan_en = 1'b0;
      test_mode = 1'b1;
      #1;
      chk("R4 R8 control hold", ctl_dst, p);
    end

    // Observation sweep, control chain shifting in the same cycles.
    for (int v = 0; v < 16; v++) begin
      int w;
      w = (v * 5 + 3) % 16;
      obs_node = v[N-1:0];
      scan_en = 1'b0;
      test_mode = v[0];        // R8: test mode must not affect capture
      ctl_si = 1'b0;
      edge1();                 // R2 capture
      test_mode = 1'b1;
      obs_node = ~v[N-1:0];    // changes during shift must not matter
      scan_en = 1'b1;
      for (int k = 0; k < N; k++) begin
        chk("R2 R3 R7 captured bit out", obs_so, v[N-1-k]);
        obs_si = w[N-1-k];
        ctl_si = v[N-1-k];
        edge1();
      end
      chk("R4 R8 concurrent control load", ctl_dst, v);
      for (int k = 0; k < N; k++) begin
        chk("R3 R7 shifted-in bit out", obs_so, w[N-1-k]);
        obs_si = 1'b0;
        edge1();
      end
    end

    // R1: reset during active shifting takes priority
    test_mode = 1'b1;
    scan_en = 1'b1;
    ctl_si = 1'b1;
    obs_si = 1'b1;
    for (int k = 0; k < N; k++) edge1();
    chk("R6 all ones loaded", ctl_dst, 15);
    rst = 1'b1;
    edge1();
    chk("R1 reset beats shift ctl", ctl_dst, 0);
    chk("R1 reset beats shift obs", obs_so, 0);
    rst = 1'b0;
    test_mode = 1'b0;
    scan_en = 1'b0;
    edge1();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule